// File: doc/BRIEF.md
# All-Digital Trunk Timing PLL Core

This block is the loop core of a fully digital phase-locked loop for T1/E1 trunk timing. It runs on a nominal 20 MHz master clock. A 32-bit phase accumulator produces a nominal 16.384 MHz output phase. A fractional feedback divider turns the accumulator's wrap strobe into a feedback tick whose rate equals the chosen reference rate. A phase detector measures the reference's rising edge against the feedback tick as a signed count of master-clock cycles. A first-order low-pass filter smooths those measurements into a signed correction, which is added to the accumulator increment.

The reference rate comes from a 2-bit select: 01 selects 8 kHz, 10 selects 1.544 MHz, 11 selects 2.048 MHz, and 00 is reserved. The mode bit picks tracking (0) or free-running (1). In free-running mode, or with the reserved code, the loop is opened: the reference is ignored, the filter is cleared and the accumulator runs at its nominal increment. Downstream logic uses the phase word and the two strobes to build clocks and frame pulses.

The phase detector is a three-state machine:
- `PD_IDLE` waits for an edge.
- `PD_REF_LEAD` counts cycles after a reference edge until a feedback tick arrives.
- `PD_FB_LEAD` counts cycles after a feedback tick until a reference edge arrives.

Its transitions are:
- **ref-first**: IDLE to REF_LEAD.
- **fb-first**: IDLE to FB_LEAD.
- **tie**: IDLE to IDLE, with a zero result.
- **close-positive**: REF_LEAD to IDLE.
- **close-negative**: FB_LEAD to IDLE.
- **restart**: a repeated leading edge, which stays in the same state with the count reset to 1.
- **open-loop**: any state to IDLE while the loop is open.

Top module: `trunk_pll_core`

## Requirements
- R1: While `rst_n` is low, `nco_phase` is 0 and `nco_wrap` and `fb_tick` are 0. The loop filter, the detector state and the feedback divider return to zero or IDLE.
- R2: Each master-clock cycle, `nco_phase` advances by the increment modulo 2^32. The increment is the nominal value round(16384/20000 * 2^32) = 3518437209 plus the current filter correction. `nco_wrap` is high for the cycle after a step that carried out of bit 31.
- R3: The feedback divider keeps an 11-bit fraction. In the cycle after `nco_wrap` is high, it adds a step of 1 (select 01), 193 (select 10) or 256 (select 11) to the fraction. `fb_tick` is high for the cycle that follows an addition that carried past 2047. `fb_tick` is low at all other times.
- R4: When `free_run` is 1, the increment equals the nominal value in every cycle and the reference input has no effect. The filter correction is cleared at the next edge.
- R5: With `freq_sel` = 00, the loop is open exactly as in R4, and `fb_tick` stays low.
- R6: The reference passes through a two-flop synchronizer, and a rising edge is detected one flop later. When a reference edge leads, the result is +N, where N is the number of cycles from the reference edge to the feedback tick. When a feedback tick leads, the result is -N. Each result is presented for exactly one cycle.
- R7: A reference edge and a feedback tick in the same cycle while the detector is IDLE produce a result of 0.
- R8: On each result e, the correction y becomes y + ((e * 2^ESH - y) >>> FSH), an arithmetic shift. The new correction applies from the following cycle.
- R9: The detector count saturates at 2^CNT_W - 1 and never wraps.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_mclk | input | 1 | Master clock, nominally 20 MHz |
| rst_n | input | 1 | Asynchronous reset, active low |
| ref_in | input | 1 | Reference input, asynchronous to the master clock |
| freq_sel | input | 2 | Reference rate: 00 reserved, 01 8 kHz, 10 1.544 MHz, 11 2.048 MHz |
| free_run | input | 1 | 0 tracks the reference, 1 runs free at the nominal rate |
| nco_phase | output | ACC_W | Accumulator phase word |
| nco_wrap | output | 1 | Accumulator carry strobe, one cycle wide |
| fb_tick | output | 1 | Feedback divider strobe at the reference rate |

## Verification
Two events can land in the same master-clock cycle: a detected reference edge and a feedback tick. If they do while the detector is idle, the result must be a tie (zero). If a feedback tick and a further reference edge arrive together while a lead is already being counted, the lead must close and the new edge must not restart the count.

The bench provokes both cases with a 2.048 MHz-select reference whose period of 10 cycles slides past the feedback tick period of about 9.77 cycles. While the loop pulls in, the edges drift through coincidence repeatedly. A behavioural model predicts the phase word and both strobes on every clock. A separate tally confirms that ties, leads of both signs and saturated counts all occurred.

// File: rtl/trunk_pll_pkg.sv
package trunk_pll_pkg;

    typedef enum logic [1:0] {
        PD_IDLE     = 2'd0,
        PD_REF_LEAD = 2'd1,
        PD_FB_LEAD  = 2'd2
    } pd_state_e;

    localparam logic [1:0] SEL_RSVD = 2'b00;
    localparam logic [1:0] SEL_8K   = 2'b01;
    localparam logic [1:0] SEL_T1   = 2'b10;
    localparam logic [1:0] SEL_E1   = 2'b11;

    localparam int REF_KHZ_8K = 8;
    localparam int REF_KHZ_T1 = 1544;
    localparam int REF_KHZ_E1 = 2048;

endpackage

// File: rtl/tpll_nco.sv
module tpll_nco #(
    parameter int ACC_W    = 32,
    parameter int CORR_W   = 22,
    parameter int MCLK_KHZ = 20000,
    parameter int OUT_KHZ  = 16384
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     active,
    input  logic signed [CORR_W-1:0] corr,
    output logic [ACC_W-1:0]         phase,
    output logic                     wrap
);
    localparam logic [ACC_W-1:0] NOM_INC =
        ACC_W'(((64'(OUT_KHZ) << ACC_W) + 64'(MCLK_KHZ / 2)) / 64'(MCLK_KHZ));

    logic [ACC_W:0] corr_ext;
    logic [ACC_W:0] inc_u;
    logic [ACC_W:0] sum;

    always_comb begin
        corr_ext = (ACC_W+1)'(corr);
        inc_u    = {1'b0, NOM_INC} + (active ? corr_ext : '0);
        sum      = {1'b0, phase} + inc_u;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            phase <= '0;
            wrap  <= 1'b0;
        end else begin
            phase <= sum[ACC_W-1:0];
            wrap  <= sum[ACC_W];
        end
    end

    AST_INC_POSITIVE: assert property (@(posedge clk) disable iff (!rst_n)
        !inc_u[ACC_W]); // R2
    AST_NOMINAL_OPEN: assert property (@(posedge clk) disable iff (!rst_n)
        !active |=> (phase == $past(phase) + NOM_INC)); // R4

endmodule

// File: rtl/tpll_fb_div.sv
module tpll_fb_div
    import trunk_pll_pkg::*;
#(
    parameter int FRAC_W  = 11,
    parameter int OUT_KHZ = 16384
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic [1:0] freq_sel,
    input  logic       wrap_in,
    output logic       tick
);
    localparam logic [FRAC_W:0] STEP_8K = (FRAC_W+1)'((REF_KHZ_8K * (2 ** FRAC_W)) / OUT_KHZ);
    localparam logic [FRAC_W:0] STEP_T1 = (FRAC_W+1)'((REF_KHZ_T1 * (2 ** FRAC_W)) / OUT_KHZ);
    localparam logic [FRAC_W:0] STEP_E1 = (FRAC_W+1)'((REF_KHZ_E1 * (2 ** FRAC_W)) / OUT_KHZ);

    logic [FRAC_W-1:0] frac;
    logic [FRAC_W:0]   step;
    logic [FRAC_W:0]   sum;

    always_comb begin
        unique case (freq_sel)
            SEL_8K:  step = STEP_8K;
            SEL_T1:  step = STEP_T1;
            SEL_E1:  step = STEP_E1;
            default: step = '0;
        endcase
        sum = {1'b0, frac} + step;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            frac <= '0;
            tick <= 1'b0;
        end else if (wrap_in) begin
            frac <= sum[FRAC_W-1:0];
            tick <= sum[FRAC_W];
        end else begin
            tick <= 1'b0;
        end
    end

    AST_TICK_NEEDS_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
        tick |-> $past(wrap_in)); // R3
    AST_RSVD_NO_TICK: assert property (@(posedge clk) disable iff (!rst_n)
        (freq_sel == SEL_RSVD) |=> !tick); // R5

endmodule

// File: rtl/tpll_phase_det.sv
module tpll_phase_det
    import trunk_pll_pkg::*;
#(
    parameter int CNT_W = 12
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                active,
    input  logic                ref_in,
    input  logic                fb_tick,
    output logic                err_vld,
    output logic signed [CNT_W:0] err_val
);
    localparam logic [CNT_W-1:0] CNT_MAX = '1;
    localparam logic [CNT_W-1:0] CNT_ONE = CNT_W'(1);

    logic              ref_s1, ref_s2, ref_d;
    logic              ref_hit, fb_hit;
    logic [CNT_W-1:0]  cnt_q, cnt_inc;
    pd_state_e         state_q, state_d;

    // two-flop synchronizer plus edge-detect flop
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ref_s1 <= 1'b0;
            ref_s2 <= 1'b0;
            ref_d  <= 1'b0;
        end else begin
            ref_s1 <= ref_in;
            ref_s2 <= ref_s1;
            ref_d  <= ref_s2;
        end
    end

    always_comb begin
        ref_hit = ref_s2 & ~ref_d & active;
        fb_hit  = fb_tick & active;
        cnt_inc = (cnt_q == CNT_MAX) ? cnt_q : cnt_q + CNT_ONE;
    end

    // next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            PD_IDLE: begin
                if (ref_hit && !fb_hit)      state_d = PD_REF_LEAD;
                else if (fb_hit && !ref_hit) state_d = PD_FB_LEAD;
            end
            PD_REF_LEAD: if (fb_hit)  state_d = PD_IDLE;
            PD_FB_LEAD:  if (ref_hit) state_d = PD_IDLE;
            default: state_d = PD_IDLE;
        endcase
        if (!active) state_d = PD_IDLE;
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= PD_IDLE;
        else        state_q <= state_d;
    end

    // output and counter process
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q   <= '0;
            err_vld <= 1'b0;
            err_val <= '0;
        end else if (!active) begin
            cnt_q   <= '0;
            err_vld <= 1'b0;
            err_val <= '0;
        end else begin
            err_vld <= 1'b0;
            unique case (state_q)
                PD_IDLE: begin
                    if (ref_hit && fb_hit) begin
                        err_vld <= 1'b1;
                        err_val <= '0;
                    end else if (ref_hit || fb_hit) begin
                        cnt_q <= CNT_ONE;
                    end
                end
                PD_REF_LEAD: begin
                    if (fb_hit) begin
                        err_vld <= 1'b1;
                        err_val <= $signed({1'b0, cnt_q});
                    end else if (ref_hit) begin
                        cnt_q <= CNT_ONE;
                    end else begin
                        cnt_q <= cnt_inc;
                    end
                end
                PD_FB_LEAD: begin
                    if (ref_hit) begin
                        err_vld <= 1'b1;
                        err_val <= -$signed({1'b0, cnt_q});
                    end else if (fb_hit) begin
                        cnt_q <= CNT_ONE;
                    end else begin
                        cnt_q <= cnt_inc;
                    end
                end
                default: cnt_q <= '0;
            endcase
        end
    end

    AST_TIE_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == PD_IDLE && ref_hit && fb_hit) |=> (err_vld && err_val == 0)); // R7
    AST_LEAD_POSITIVE: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == PD_REF_LEAD && fb_hit) |=> (err_vld && err_val > 0)); // R6
    AST_LAG_NEGATIVE: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == PD_FB_LEAD && ref_hit) |=> (err_vld && err_val < 0)); // R6
    AST_CNT_HOLDS_MAX: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == PD_REF_LEAD && !fb_hit && !ref_hit && cnt_q == CNT_MAX)
        |=> (cnt_q == CNT_MAX)); // R9
    AST_OPEN_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        !active |=> (state_q == PD_IDLE && !err_vld)); // R4

endmodule

// File: rtl/tpll_loop_filter.sv
module tpll_loop_filter #(
    parameter int E_W = 13,
    parameter int Y_W = 26,
    parameter int ESH = 12,
    parameter int FSH = 6
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  active,
    input  logic                  err_vld,
    input  logic signed [E_W-1:0] err_val,
    output logic signed [Y_W-1:0] corr
);
    logic signed [Y_W:0] tgt, y_ext, diff, stepv, y_nx;

    always_comb begin
        tgt   = (Y_W+1)'(err_val) <<< ESH;
        y_ext = $signed({corr[Y_W-1], corr});
        diff  = tgt - y_ext;
        stepv = diff >>> FSH;
        y_nx  = y_ext + stepv;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)       corr <= '0;
        else if (!active) corr <= '0;
        else if (err_vld) corr <= y_nx[Y_W-1:0];
    end

    AST_FILTER_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
        !active |=> (corr == 0)); // R4
    AST_FILTER_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
        y_nx[Y_W] == y_nx[Y_W-1]); // R8
    AST_FILTER_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (active && !err_vld) |=> $stable(corr)); // R8

endmodule

// File: rtl/trunk_pll_core.sv
module trunk_pll_core
    import trunk_pll_pkg::*;
#(
    parameter int ACC_W    = 32,
    parameter int MCLK_KHZ = 20000,
    parameter int OUT_KHZ  = 16384,
    parameter int FRAC_W   = 11,
    parameter int CNT_W    = 12,
    parameter int ESH      = 12,
    parameter int FSH      = 6
) (
    input  logic             clk_mclk,
    input  logic             rst_n,
    input  logic             ref_in,
    input  logic [1:0]       freq_sel,
    input  logic             free_run,
    output logic [ACC_W-1:0] nco_phase,
    output logic             nco_wrap,
    output logic             fb_tick
);
    localparam int E_W = CNT_W + 1;
    localparam int Y_W = CNT_W + ESH + 2;

    logic                  loop_on;
    logic                  err_vld;
    logic signed [E_W-1:0] err_val;
    logic signed [Y_W-1:0] corr;

    assign loop_on = !free_run && (freq_sel != SEL_RSVD);

    tpll_phase_det #(.CNT_W(CNT_W)) u_pd (
        .clk     (clk_mclk),
        .rst_n   (rst_n),
        .active  (loop_on),
        .ref_in  (ref_in),
        .fb_tick (fb_tick),
        .err_vld (err_vld),
        .err_val (err_val)
    );

    tpll_loop_filter #(.E_W(E_W), .Y_W(Y_W), .ESH(ESH), .FSH(FSH)) u_lf (
        .clk     (clk_mclk),
        .rst_n   (rst_n),
        .active  (loop_on),
        .err_vld (err_vld),
        .err_val (err_val),
        .corr    (corr)
    );

    tpll_nco #(.ACC_W(ACC_W), .CORR_W(Y_W), .MCLK_KHZ(MCLK_KHZ), .OUT_KHZ(OUT_KHZ)) u_nco (
        .clk    (clk_mclk),
        .rst_n  (rst_n),
        .active (loop_on),
        .corr   (corr),
        .phase  (nco_phase),
        .wrap   (nco_wrap)
    );

    tpll_fb_div #(.FRAC_W(FRAC_W), .OUT_KHZ(OUT_KHZ)) u_div (
        .clk      (clk_mclk),
        .rst_n    (rst_n),
        .freq_sel (freq_sel),
        .wrap_in  (nco_wrap),
        .tick     (fb_tick)
    );

    AST_RESET_QUIET: assert property (@(posedge clk_mclk) disable iff (!rst_n)
        $rose(nco_wrap) |-> $past(rst_n)); // R1

endmodule

// File: tb/test_trunk_pll_core.sv
`timescale 1ns/1ps
module test_trunk_pll_core;
    localparam int  CNT_W = 8;
    localparam int  ESH   = 12;
    localparam int  FSH   = 4;
    localparam longint NOM  = 64'd3518437209;
    localparam longint TWO32 = 64'd4294967296;
    localparam int  CMAX  = 255;
    localparam int  WD    = 190000;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        ref_in = 1'b0;
    logic [1:0]  freq_sel = 2'b01;
    logic        free_run = 1'b1;
    logic [31:0] nco_phase;
    logic        nco_wrap;
    logic        fb_tick;

    always #2 clk = ~clk;

    trunk_pll_core #(.CNT_W(CNT_W), .ESH(ESH), .FSH(FSH)) i_trunk_pll_core (
        .clk_mclk (clk), .rst_n (rst_n), .ref_in (ref_in), .freq_sel (freq_sel),
        .free_run (free_run), .nco_phase (nco_phase), .nco_wrap (nco_wrap), .fb_tick (fb_tick)
    );

    int errors = 0;
    int checks = 0;
    int cyc = 0;
    bit done = 0;

    task automatic chk(input string tag, input longint act, input longint exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
        end
    endtask

    task automatic summary();
        $display("Result: errors=%0d of %0d checks", errors, checks);
    endtask

    // reference generator: period in cycles, high for half
    int ref_per = 0;
    int ref_cnt = 0;
    always @(negedge clk) begin
        if (ref_per > 0) begin
            ref_cnt = (ref_cnt + 1) % ref_per;
            ref_in <= (ref_cnt < ref_per / 2);
        end
    end

    // behavioural model
    longint m_phase, m_y, m_err;
    int m_wrap, m_tick, m_frac, m_state, m_cnt, m_ev, m_s1, m_s2, m_d;
    int n_ties, n_pos, n_neg, n_sats;
    always @(posedge clk) begin
        if (!rst_n) begin
            m_phase = 0; m_y = 0; m_err = 0; m_wrap = 0; m_tick = 0; m_frac = 0;
            m_state = 0; m_cnt = 0; m_ev = 0; m_s1 = 0; m_s2 = 0; m_d = 0;
        end else begin
            automatic bit act = !free_run && (freq_sel != 2'b00);
            automatic bit r = act && m_s2 && !m_d;
            automatic bit f = act && (m_tick != 0);
            automatic longint sum = m_phase + NOM + (act ? m_y : 0);
            automatic int step = (freq_sel == 2'b01) ? 1 : (freq_sel == 2'b10) ? 193 :
                                 (freq_sel == 2'b11) ? 256 : 0;
            automatic int n_tick = 0, n_frac = m_frac, n_state = m_state, n_cnt = m_cnt, n_ev = 0;
            automatic longint n_y = m_y, n_err = m_err;
            if (m_wrap != 0) begin
                n_tick = (m_frac + step >= 2048);
                n_frac = (m_frac + step) % 2048;
            end
            if (!act) n_y = 0;
            else if (m_ev != 0) n_y = m_y + (((m_err <<< ESH) - m_y) >>> FSH);   // R8
            if (!act) begin
                n_state = 0; n_cnt = 0; n_err = 0;
            end else begin
                case (m_state)
                    0: if (r && f) begin n_ev = 1; n_err = 0; n_ties++; end  // R7
                       else if (r) begin n_state = 1; n_cnt = 1; end
                       else if (f) begin n_state = 2; n_cnt = 1; end
                    1: if (f) begin n_ev = 1; n_err = m_cnt; n_state = 0; n_pos++; end
                       else if (r) n_cnt = 1;
                       else n_cnt = (m_cnt == CMAX) ? CMAX : m_cnt + 1;
                    default: if (r) begin n_ev = 1; n_err = -m_cnt; n_state = 0; n_neg++; end
                       else if (f) n_cnt = 1;
                       else n_cnt = (m_cnt == CMAX) ? CMAX : m_cnt + 1;
                endcase
                if (m_state != 0 && n_state == m_state && m_cnt == CMAX && n_cnt == CMAX) n_sats++;  // R9
            end
            m_d = m_s2; m_s2 = m_s1; m_s1 = ref_in;
            m_phase = sum % TWO32; m_wrap = int'(sum / TWO32);
            m_tick = n_tick; m_frac = n_frac; m_y = n_y; m_err = n_err;
            m_state = n_state; m_cnt = n_cnt; m_ev = n_ev;
        end
    end

    // per-clock comparison and port-level tallies
    longint prev_phase = 0;
    bit prev_ok = 0;
    int cnt_nonnom = 0;
    int cnt_ticks = 0;
    always @(negedge clk) begin
        if (rst_n && !done) begin
            chk("R2 nco_phase", nco_phase, m_phase);
            chk("R2 nco_wrap", nco_wrap, m_wrap);
            chk("R3 fb_tick", fb_tick, m_tick);
            if (prev_ok && ((longint'(nco_phase) - prev_phase + TWO32) % TWO32) != NOM) cnt_nonnom++;
            if (fb_tick) cnt_ticks++;
            prev_phase = nco_phase;
            prev_ok = 1;
        end else begin
            prev_ok = 0;
        end
    end

    always @(posedge clk) begin
        cyc++;
        if (cyc == WD && !done) begin
            errors++; checks++;
            $display("FAIL watchdog: actual %0d expected below %0d cycles", cyc, WD);
            summary();
            $finish;
        end
    end

    task automatic run(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic set_mode(input logic fr, input logic [1:0] fs, input int per);
        free_run = fr; freq_sel = fs; ref_per = per;
        run(4);
        cnt_nonnom = 0; cnt_ticks = 0;
    endtask

    task automatic check_reset();
        @(negedge clk); #1 rst_n = 1'b0;
        run(2);
        chk("R1 phase in reset", nco_phase, 0);
        chk("R1 wrap in reset", nco_wrap, 0);
        chk("R1 tick in reset", fb_tick, 0);
        #1 rst_n = 1'b1;
    endtask

    initial begin
        run(3);
        chk("R1 phase in reset", nco_phase, 0);
        chk("R1 wrap in reset", nco_wrap, 0);
        chk("R1 tick in reset", fb_tick, 0);
        #1 rst_n = 1'b1;

        // R4: free-running, reference toggling but ignored
        set_mode(1'b1, 2'b01, 2500);
        run(3000);
        chk("R4 non-nominal steps in freerun", cnt_nonnom, 0);

        // R5: reserved select opens the loop and silences the divider
        set_mode(1'b0, 2'b00, 10);
        run(3000);
        chk("R5 ticks with reserved select", cnt_ticks, 0);
        chk("R5 non-nominal steps with reserved select", cnt_nonnom, 0);

        // 2.048 MHz select, reference period 10 cycles
        set_mode(1'b0, 2'b11, 10);
        run(20000);
        chk("R8 correction applied", (cnt_nonnom > 0), 1);
        chk("R3 feedback ticks seen", (cnt_ticks > 0), 1);

        check_reset();

        // 1.544 MHz select, reference period 13 cycles
        set_mode(1'b0, 2'b10, 13);
        run(20000);
        // 8 kHz select, nominal reference
        set_mode(1'b0, 2'b01, 2500);
        run(40000);
        // 8 kHz select, slow reference forcing long leads
        set_mode(1'b0, 2'b01, 9000);
        run(30000);

        chk("R6 positive results occurred", (n_pos > 0), 1);
        chk("R6 negative results occurred", (n_neg > 0), 1);
        chk("R7 tie results occurred", (n_ties > 0), 1);
        chk("R9 saturated counts occurred", (n_sats > 0), 1);

        done = 1;
        summary();
        $finish;
    end

endmodule